// File: doc/BRIEF.md
# Rename register file allocator

This block holds the rename entries of an out-of-order core together with the architectural register table that points into them. When an instruction with a destination register is dispatched, the block picks the free rename entry with the lowest index and claims it. It records which architectural register that entry will update. In the same clock edge it marks that architectural register as renamed and points it at the new tag.

Execution results come back by tag and fill the entry's data. A lookup port on the rename side forwards a result that arrives in the same cycle, so a consumer that reads the tag while the result is written sees the new value. When an entry retires, its data is copied into the architectural register. The register is released only if it still points at the retiring tag; if a younger rename has since taken it over, the register stays renamed. The retired entry then returns to the free pool. The allocation tag and a space-available flag are combinational, so dispatch logic can test for room and use the tag in the same cycle.

Top module: `rename_file`

## Requirements
- R1: After reset every rename entry is free and not valid, every architectural register is not renamed, `space_avail` is 1 and `alloc_tag` is 0.
- R2: `alloc_tag` always shows the lowest-index rename entry that is not busy, and an allocation claims exactly that entry.
- R3: An allocation (`alloc_req`=1, `alloc_dest_vld`=1, `space_avail`=1) leaves the claimed entry busy, not valid and holding `alloc_dest` from the next cycle. The same edge sets the architectural register `alloc_dest` to renamed, with its tag equal to the claimed index.
- R4: A request with `alloc_dest_vld`=0 (no destination register) claims no entry and renames no architectural register.
- R5: `space_avail` is 0 exactly when every rename entry is busy, and an allocation request made while it is 0 is ignored.
- R6: A writeback (`wb_en`=1) stores `wb_data` in entry `wb_tag` and makes it valid from the next cycle. In the cycle of the writeback itself, a rename lookup of that tag already returns valid=1 and `wb_data`.
- R7: A retire (`ret_en`=1) copies the entry's data into its destination architectural register and frees the entry. If a writeback to the same tag happens in the same cycle, the written value is the one copied.
- R8: A retire clears the destination register's renamed flag only when that register's tag equals `ret_tag`. Otherwise the flag and the tag are kept.
- R9: When an allocation and a retire address the same architectural register in one cycle, the allocation wins: the register stays renamed and takes the new tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_req | input | 1 | Dispatch asks for a rename entry this cycle |
| alloc_dest_vld | input | 1 | The instruction has a destination register |
| alloc_dest | input | $clog2(NUM_ARCH) | Destination architectural register |
| alloc_tag | output | $clog2(NUM_RR) | Lowest free entry index, the tag an allocation gets |
| space_avail | output | 1 | At least one rename entry is free |
| wb_en | input | 1 | Result writeback strobe |
| wb_tag | input | $clog2(NUM_RR) | Rename entry that receives the result |
| wb_data | input | DATA_W | Result value |
| ret_en | input | 1 | Retire strobe |
| ret_tag | input | $clog2(NUM_RR) | Rename entry being retired |
| arch_rd_idx | input | $clog2(NUM_ARCH) | Architectural register to look up |
| arch_rd_busy | output | 1 | That register is renamed |
| arch_rd_tag | output | $clog2(NUM_RR) | Rename tag of that register |
| arch_rd_data | output | DATA_W | Committed value of that register |
| rr_rd_tag | input | $clog2(NUM_RR) | Rename entry to look up |
| rr_rd_valid | output | 1 | That entry holds a result (writeback forwarded) |
| rr_rd_data | output | DATA_W | Result held by that entry (writeback forwarded) |
| rr_rd_dest | output | $clog2(NUM_ARCH) | Destination register recorded in that entry |

## Verification
Three results are due in the same cycle as the stimulus, because they are combinational: `alloc_tag`, `space_avail` and a rename lookup that hits an incoming writeback. Everything else appears one rising edge after the stimulus: claimed entries, renamed registers, stored data, freed entries and retired values. The driver applies a stimulus just after a falling edge. It tags each expectation with the window between two rising edges in which it is due: the same window for the combinational results, the next window for the registered ones. The monitor compares each expectation only when its window is open, about a quarter period before the next rising edge.

// File: rtl/rrf_pkg.sv
package rrf_pkg;

   // How the free-entry picker is built; both give the lowest free index.
   typedef enum logic [0:0] {
      PICK_CHAIN = 1'b0,   // ripple chain of "already granted" bits
      PICK_SCAN  = 1'b1    // behavioural scan loop
   } pick_style_e;

   // Whether a same-cycle writeback is forwarded to rename-side readers.
   typedef enum logic [0:0] {
      FWD_OFF = 1'b0,
      FWD_ON  = 1'b1
   } wb_fwd_e;

endpackage

// File: rtl/rrf_free_pick.sv
module rrf_free_pick #(
   parameter int unsigned          N     = 16,
   parameter rrf_pkg::pick_style_e STYLE = rrf_pkg::PICK_CHAIN
) (
   input  logic [N-1:0]         free_i,
   output logic [N-1:0]         grant_o,
   output logic [$clog2(N)-1:0] idx_o,
   output logic                 any_o
);

   localparam int unsigned IW = $clog2(N);

   if (N < 2) begin : g_bad_n
      $error("rrf_free_pick: N must be at least 2");
   end

   if (STYLE == rrf_pkg::PICK_CHAIN) begin : g_chain
      logic [N:0] seen;
      assign seen[0] = 1'b0;
      for (genvar i = 0; i < N; i++) begin : g_bit
         assign grant_o[i]  = free_i[i] & ~seen[i];
         assign seen[i + 1] = seen[i] | free_i[i];
      end
      assign any_o = seen[N];
   end else begin : g_scan
      logic found;
      always_comb begin
         grant_o = '0;
         found   = 1'b0;
         for (int i = 0; i < N; i++) begin
            if (free_i[i] && !found) begin
               grant_o[i] = 1'b1;
               found      = 1'b1;
            end
         end
      end
      assign any_o = found;
   end

   // one-hot to binary
   always_comb begin
      idx_o = '0;
      for (int i = 0; i < N; i++) begin
         if (grant_o[i]) idx_o = idx_o | IW'(i);
      end
   end

endmodule

// File: rtl/rrf_entry_tbl.sv
module rrf_entry_tbl #(
   parameter int unsigned      N   = 16,
   parameter int unsigned      NA  = 32,
   parameter int unsigned      DW  = 64,
   parameter rrf_pkg::wb_fwd_e FWD = rrf_pkg::FWD_ON
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  alloc_fire,
   input  logic [$clog2(N)-1:0]  alloc_idx,
   input  logic [$clog2(NA)-1:0] alloc_dest,
   input  logic                  wb_en,
   input  logic [$clog2(N)-1:0]  wb_tag,
   input  logic [DW-1:0]         wb_data,
   input  logic                  ret_en,
   input  logic [$clog2(N)-1:0]  ret_tag,
   output logic [$clog2(NA)-1:0] ret_dest,
   output logic [DW-1:0]         ret_data,
   output logic [N-1:0]          busy_o,
   input  logic [$clog2(N)-1:0]  rd_tag,
   output logic                  rd_valid,
   output logic [DW-1:0]         rd_data,
   output logic [$clog2(NA)-1:0] rd_dest
);

   localparam int unsigned TW = $clog2(N);
   localparam int unsigned AW = $clog2(NA);

   if ((1 << TW) != N) begin : g_bad_n
      $error("rrf_entry_tbl: N must be a power of two");
   end
   if (DW < 1) begin : g_bad_dw
      $error("rrf_entry_tbl: DW must be positive");
   end

   logic [N-1:0]  busy_q;
   logic [N-1:0]  valid_q;
   logic [DW-1:0] data_q [N];
   logic [AW-1:0] dest_q [N];

   // control bits: retire beats writeback, alloc only hits free entries
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= '0;
         valid_q <= '0;
      end else begin
         for (int e = 0; e < N; e++) begin
            if (ret_en && ret_tag == TW'(e)) begin
               busy_q[e]  <= 1'b0;
               valid_q[e] <= 1'b0;
            end else if (alloc_fire && alloc_idx == TW'(e)) begin
               busy_q[e]  <= 1'b1;
               valid_q[e] <= 1'b0;
            end else if (wb_en && wb_tag == TW'(e)) begin
               valid_q[e] <= 1'b1;
            end
         end
      end
   end

   // payload: left unreset, meaningful only while valid / busy
   always_ff @(posedge clk) begin
      if (alloc_fire) dest_q[alloc_idx] <= alloc_dest;
      if (wb_en)      data_q[wb_tag]    <= wb_data;
   end

   assign busy_o   = busy_q;
   assign rd_dest  = dest_q[rd_tag];
   assign ret_dest = dest_q[ret_tag];

   if (FWD == rrf_pkg::FWD_ON) begin : g_fwd
      logic rd_hit, ret_hit;
      assign rd_hit   = wb_en && (wb_tag == rd_tag);
      assign ret_hit  = wb_en && (wb_tag == ret_tag);
      assign rd_valid = valid_q[rd_tag] | rd_hit;
      assign rd_data  = rd_hit  ? wb_data : data_q[rd_tag];
      assign ret_data = ret_hit ? wb_data : data_q[ret_tag];
   end else begin : g_nofwd
      assign rd_valid = valid_q[rd_tag];
      assign rd_data  = data_q[rd_tag];
      assign ret_data = data_q[ret_tag];
   end

   // the picker must only offer an entry that is free here
   assert_alloc_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_fire |-> !busy_q[alloc_idx]);

   assert_alloc_claim_R3: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_fire |=> busy_q[$past(alloc_idx)] && !valid_q[$past(alloc_idx)]
                     && dest_q[$past(alloc_idx)] == $past(alloc_dest));

   assert_wb_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && busy_q[wb_tag] && !(ret_en && ret_tag == wb_tag))
      |=> valid_q[$past(wb_tag)] && data_q[$past(wb_tag)] == $past(wb_data));

   assert_ret_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ret_en |=> !busy_q[$past(ret_tag)] && !valid_q[$past(ret_tag)]);

endmodule

// File: rtl/rrf_arch_tbl.sv
module rrf_arch_tbl #(
   parameter int unsigned NA = 32,
   parameter int unsigned N  = 16,
   parameter int unsigned DW = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  alloc_fire,
   input  logic [$clog2(NA)-1:0] alloc_dest,
   input  logic [$clog2(N)-1:0]  alloc_tag,
   input  logic                  ret_en,
   input  logic [$clog2(NA)-1:0] ret_dest,
   input  logic [$clog2(N)-1:0]  ret_tag,
   input  logic [DW-1:0]         ret_data,
   input  logic [$clog2(NA)-1:0] rd_idx,
   output logic                  rd_busy,
   output logic [$clog2(N)-1:0]  rd_tag,
   output logic [DW-1:0]         rd_data
);

   localparam int unsigned TW = $clog2(N);
   localparam int unsigned AW = $clog2(NA);

   if ((1 << AW) != NA || NA < 2) begin : g_bad_na
      $error("rrf_arch_tbl: NA must be a power of two, at least 2");
   end

   logic [NA-1:0] busy_q;
   logic [TW-1:0] tag_q  [NA];
   logic [DW-1:0] data_q [NA];

   // rename wins over a same-cycle release of the same register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= '0;
         for (int i = 0; i < NA; i++) tag_q[i] <= '0;
      end else begin
         for (int i = 0; i < NA; i++) begin
            if (alloc_fire && alloc_dest == AW'(i)) begin
               busy_q[i] <= 1'b1;
               tag_q[i]  <= alloc_tag;
            end else if (ret_en && ret_dest == AW'(i) && busy_q[i]
                         && tag_q[i] == ret_tag) begin
               busy_q[i] <= 1'b0;
            end
         end
      end
   end

   // committed values: written on every retire, tag match or not
   always_ff @(posedge clk) begin
      if (ret_en) data_q[ret_dest] <= ret_data;
   end

   assign rd_busy = busy_q[rd_idx];
   assign rd_tag  = tag_q[rd_idx];
   assign rd_data = data_q[rd_idx];

   // R3 and R9: the newest rename always sticks
   assert_rename_R3: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_fire |=> busy_q[$past(alloc_dest)]
                     && tag_q[$past(alloc_dest)] == $past(alloc_tag));

   assert_stale_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_en && busy_q[ret_dest] && tag_q[ret_dest] != ret_tag)
      |=> busy_q[$past(ret_dest)]);

   assert_match_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_en && busy_q[ret_dest] && tag_q[ret_dest] == ret_tag
       && !(alloc_fire && alloc_dest == ret_dest))
      |=> !busy_q[$past(ret_dest)]);

   assert_ret_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ret_en |=> data_q[$past(ret_dest)] == $past(ret_data));

endmodule

// File: rtl/rename_file.sv
module rename_file #(
   parameter int unsigned          NUM_RR   = 16,
   parameter int unsigned          NUM_ARCH = 32,
   parameter int unsigned          DATA_W   = 64,
   parameter rrf_pkg::pick_style_e PICK     = rrf_pkg::PICK_CHAIN,
   parameter rrf_pkg::wb_fwd_e     FWD      = rrf_pkg::FWD_ON
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        alloc_req,
   input  logic                        alloc_dest_vld,
   input  logic [$clog2(NUM_ARCH)-1:0] alloc_dest,
   output logic [$clog2(NUM_RR)-1:0]   alloc_tag,
   output logic                        space_avail,
   input  logic                        wb_en,
   input  logic [$clog2(NUM_RR)-1:0]   wb_tag,
   input  logic [DATA_W-1:0]           wb_data,
   input  logic                        ret_en,
   input  logic [$clog2(NUM_RR)-1:0]   ret_tag,
   input  logic [$clog2(NUM_ARCH)-1:0] arch_rd_idx,
   output logic                        arch_rd_busy,
   output logic [$clog2(NUM_RR)-1:0]   arch_rd_tag,
   output logic [DATA_W-1:0]           arch_rd_data,
   input  logic [$clog2(NUM_RR)-1:0]   rr_rd_tag,
   output logic                        rr_rd_valid,
   output logic [DATA_W-1:0]           rr_rd_data,
   output logic [$clog2(NUM_ARCH)-1:0] rr_rd_dest
);

   localparam int unsigned TW = $clog2(NUM_RR);
   localparam int unsigned AW = $clog2(NUM_ARCH);

   if ((1 << TW) != NUM_RR || NUM_RR < 2) begin : g_bad_rr
      $error("rename_file: NUM_RR must be a power of two, at least 2");
   end

   logic [NUM_RR-1:0] busy_vec;
   logic [NUM_RR-1:0] grant;
   logic [TW-1:0]     pick_idx;
   logic              pick_any;
   logic              alloc_fire;
   logic [AW-1:0]     ret_dest;
   logic [DATA_W-1:0] ret_data;

   rrf_free_pick #(.N(NUM_RR), .STYLE(PICK)) i_pick (
      .free_i  (~busy_vec),
      .grant_o (grant),
      .idx_o   (pick_idx),
      .any_o   (pick_any)
   );

   assign alloc_tag   = pick_idx;
   assign space_avail = pick_any;
   assign alloc_fire  = alloc_req && alloc_dest_vld && pick_any;

   rrf_entry_tbl #(.N(NUM_RR), .NA(NUM_ARCH), .DW(DATA_W), .FWD(FWD)) i_ent (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_fire (alloc_fire),
      .alloc_idx  (pick_idx),
      .alloc_dest (alloc_dest),
      .wb_en      (wb_en),
      .wb_tag     (wb_tag),
      .wb_data    (wb_data),
      .ret_en     (ret_en),
      .ret_tag    (ret_tag),
      .ret_dest   (ret_dest),
      .ret_data   (ret_data),
      .busy_o     (busy_vec),
      .rd_tag     (rr_rd_tag),
      .rd_valid   (rr_rd_valid),
      .rd_data    (rr_rd_data),
      .rd_dest    (rr_rd_dest)
   );

   rrf_arch_tbl #(.NA(NUM_ARCH), .N(NUM_RR), .DW(DATA_W)) i_arch (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_fire (alloc_fire),
      .alloc_dest (alloc_dest),
      .alloc_tag  (pick_idx),
      .ret_en     (ret_en),
      .ret_dest   (ret_dest),
      .ret_tag    (ret_tag),
      .ret_data   (ret_data),
      .rd_idx     (arch_rd_idx),
      .rd_busy    (arch_rd_busy),
      .rd_tag     (arch_rd_tag),
      .rd_data    (arch_rd_data)
   );

   assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && (pick_any == (grant != '0)));

   assert_full_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!space_avail && !ret_en) |=> !space_avail);

   assert_nodest_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_req && !alloc_dest_vld && !ret_en) |=> $stable(busy_vec));

endmodule

// File: tb/test_rename_file.sv
module test_rename_file;

   localparam int CLK_PERIOD = 20;
   localparam int NRR   = 4;
   localparam int NARCH = 8;
   localparam int DW    = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          alloc_req = 1'b0, alloc_dest_vld = 1'b0;
   logic [2:0]    alloc_dest = '0;
   logic [1:0]    alloc_tag;
   logic          space_avail;
   logic          wb_en = 1'b0;
   logic [1:0]    wb_tag = '0;
   logic [DW-1:0] wb_data = '0;
   logic          ret_en = 1'b0;
   logic [1:0]    ret_tag = '0;
   logic [2:0]    arch_rd_idx = '0;
   logic          arch_rd_busy;
   logic [1:0]    arch_rd_tag;
   logic [DW-1:0] arch_rd_data;
   logic [1:0]    rr_rd_tag = '0;
   logic          rr_rd_valid;
   logic [DW-1:0] rr_rd_data;
   logic [2:0]    rr_rd_dest;

   always #(CLK_PERIOD / 2) clk = ~clk;

   rename_file #(.NUM_RR(NRR), .NUM_ARCH(NARCH), .DATA_W(DW)) i_rename_file (
      .clk(clk), .rst_n(rst_n),
      .alloc_req(alloc_req), .alloc_dest_vld(alloc_dest_vld), .alloc_dest(alloc_dest),
      .alloc_tag(alloc_tag), .space_avail(space_avail),
      .wb_en(wb_en), .wb_tag(wb_tag), .wb_data(wb_data),
      .ret_en(ret_en), .ret_tag(ret_tag),
      .arch_rd_idx(arch_rd_idx), .arch_rd_busy(arch_rd_busy),
      .arch_rd_tag(arch_rd_tag), .arch_rd_data(arch_rd_data),
      .rr_rd_tag(rr_rd_tag), .rr_rd_valid(rr_rd_valid),
      .rr_rd_data(rr_rd_data), .rr_rd_dest(rr_rd_dest)
   );

   int n_chk = 0, n_fail = 0;
   int win = 0;
   bit done = 1'b0;

   always @(posedge clk) win <= win + 1;

   // scoreboard queues (one entry across all of them per expectation)
   int           q_due[$], q_kind[$], q_idx[$];
   bit           q_e1[$], q_flag[$];
   logic [31:0]  q_e2[$], q_e3[$];
   string        q_req[$];

   // reference model, built from the requirements
   bit          m_busy [NRR];
   bit          m_valid[NRR];
   logic [31:0] m_data [NRR];
   int          m_dest [NRR];
   bit          a_busy [NARCH];
   int          a_tag  [NARCH];
   logic [31:0] a_data [NARCH];
   bit          a_known[NARCH];

   task automatic push(input int due, input int kind, input int idx, input bit e1,
                       input logic [31:0] e2, input logic [31:0] e3, input bit flag,
                       input string req);
      q_due.push_back(due);  q_kind.push_back(kind); q_idx.push_back(idx);
      q_e1.push_back(e1);    q_e2.push_back(e2);     q_e3.push_back(e3);
      q_flag.push_back(flag); q_req.push_back(req);
   endtask

   function automatic int lowest_free();
      int f = -1;
      for (int i = NRR - 1; i >= 0; i--) if (!m_busy[i]) f = i;
      return f;
   endfunction

   task automatic step(input bit a_rq, input bit a_dv, input int a_dst,
                       input bit w_e, input int w_t, input logic [31:0] w_d,
                       input bit r_e, input int r_t, input string req);
      int f;
      int rdst;
      logic [31:0] rval;
      @(negedge clk);
      alloc_req = a_rq; alloc_dest_vld = a_dv; alloc_dest = 3'(a_dst);
      wb_en = w_e; wb_tag = 2'(w_t); wb_data = w_d;
      ret_en = r_e; ret_tag = 2'(r_t);
      f = lowest_free();
      // same-window results: tag/space, and a forwarded writeback
      push(win, 0, 0, f >= 0, (f >= 0) ? f : 0, 0, 1'b0, req);
      if (w_e) push(win, 2, w_t, 1'b1, w_d, m_dest[w_t], m_busy[w_t], req);
      // state after the coming edge
      if (r_e) begin
         rval = (w_e && w_t == r_t) ? w_d : m_data[r_t];
         rdst = m_dest[r_t];
         a_data[rdst]  = rval;
         a_known[rdst] = 1'b1;
         if (a_busy[rdst] && a_tag[rdst] == r_t) a_busy[rdst] = 1'b0;
      end
      if (w_e) begin m_valid[w_t] = 1'b1; m_data[w_t] = w_d; end
      if (r_e) begin m_busy[r_t] = 1'b0; m_valid[r_t] = 1'b0; end
      if (a_rq && a_dv && f >= 0) begin
         m_busy[f] = 1'b1; m_valid[f] = 1'b0; m_dest[f] = a_dst;
         a_busy[a_dst] = 1'b1; a_tag[a_dst] = f;
      end
   endtask

   task automatic idle(input string req);
      step(0, 0, 0, 0, 0, 0, 0, 0, req);
   endtask

   task automatic expect_arch(input int idx, input string req);
      push(win + 1, 1, idx, a_busy[idx], a_tag[idx], a_data[idx], a_known[idx], req);
   endtask

   task automatic expect_rr(input int tag, input string req);
      push(win + 1, 2, tag, m_valid[tag], m_data[tag], m_dest[tag], m_busy[tag], req);
   endtask

   // monitor: pops expectations whose window is open and compares
   initial begin
      int k, ix;
      bit e1, fl, bad;
      logic [31:0] e2, e3;
      string rq;
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         #(CLK_PERIOD / 4);
         while (q_due.size() > 0 && q_due[0] <= win) begin
            k = q_kind.pop_front(); ix = q_idx.pop_front();
            e1 = q_e1.pop_front();  e2 = q_e2.pop_front(); e3 = q_e3.pop_front();
            fl = q_flag.pop_front(); rq = q_req.pop_front();
            if (q_due.pop_front() < win) begin
               n_chk++; n_fail++;
               $display("FAIL %s expectation missed its window: actual late expected due", rq);
               continue;
            end
            if (k == 1) arch_rd_idx = 3'(ix);
            if (k == 2) rr_rd_tag = 2'(ix);
            #1;
            n_chk++;
            bad = 1'b0;
            case (k)
               0: begin
                  if (space_avail !== e1 || (e1 && alloc_tag !== e2[1:0])) bad = 1'b1;
                  if (bad) $display("FAIL %s space/tag: actual %0b/%0d expected %0b/%0d",
                                    rq, space_avail, alloc_tag, e1, e2);
               end
               1: begin
                  if (arch_rd_busy !== e1 || (e1 && arch_rd_tag !== e2[1:0])
                      || (fl && arch_rd_data !== e3)) bad = 1'b1;
                  if (bad) $display("FAIL %s arch[%0d] busy/tag/data: actual %0b/%0d/%0h expected %0b/%0d/%0h",
                                    rq, ix, arch_rd_busy, arch_rd_tag, arch_rd_data, e1, e2, e3);
               end
               default: begin
                  if (rr_rd_valid !== e1 || (e1 && rr_rd_data !== e2)
                      || (fl && rr_rd_dest !== e3[2:0])) bad = 1'b1;
                  if (bad) $display("FAIL %s rr[%0d] valid/data/dest: actual %0b/%0h/%0d expected %0b/%0h/%0d",
                                    rq, ix, rr_rd_valid, rr_rd_data, rr_rd_dest, e1, e2, e3);
               end
            endcase
            if (bad) n_fail++;
         end
      end
   end

   // watchdog
   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   // driver / sequence
   initial begin
      for (int i = 0; i < NRR; i++) begin
         m_busy[i] = 0; m_valid[i] = 0; m_data[i] = 0; m_dest[i] = 0;
      end
      for (int i = 0; i < NARCH; i++) begin
         a_busy[i] = 0; a_tag[i] = 0; a_data[i] = 0; a_known[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      idle("R1");                          // space=1, tag 0
      expect_arch(3, "R1"); expect_rr(0, "R1"); expect_rr(3, "R1");
      step(1, 1, 3, 0, 0, 0, 0, 0, "R3");  // alloc arch3 -> tag 0
      expect_arch(3, "R3"); expect_rr(0, "R3");
      step(1, 0, 5, 0, 0, 0, 0, 0, "R4");  // no destination: no claim
      expect_arch(5, "R4");
      step(1, 1, 5, 0, 0, 0, 0, 0, "R4");  // tag still 1 here -> arch5 tag 1
      step(1, 1, 3, 0, 0, 0, 0, 0, "R2");  // arch3 re-renamed to tag 2
      expect_arch(3, "R2");
      step(0, 0, 0, 1, 0, 32'hA5A5_0001, 0, 0, "R6"); // forwarded in same window
      expect_rr(0, "R6");
      step(0, 0, 0, 0, 0, 0, 1, 0, "R8");  // retire tag 0: arch3 now points at 2
      expect_arch(3, "R8");
      step(1, 1, 6, 0, 0, 0, 0, 0, "R7");  // freed tag 0 is lowest again
      expect_arch(6, "R7");
      step(1, 1, 7, 0, 0, 0, 0, 0, "R2");  // takes tag 3 -> full
      idle("R5");                          // space_avail low
      step(1, 1, 2, 0, 0, 0, 0, 0, "R5");  // ignored while full
      expect_arch(2, "R5");
      step(0, 0, 0, 1, 1, 32'h0000_BEEF, 1, 1, "R7"); // wb+retire tag1 (arch5)
      expect_arch(5, "R7");
      step(0, 0, 0, 1, 0, 32'h1234_5678, 0, 0, "R6");
      step(1, 1, 6, 0, 0, 0, 1, 0, "R9");  // alloc and release arch6 together
      expect_arch(6, "R9");
      step(0, 0, 0, 1, 2, 32'h0DDC_0FFE, 1, 2, "R8"); // matching tag releases arch3
      expect_arch(3, "R8");
      step(1, 1, 4, 0, 0, 0, 0, 0, "R2");
      expect_arch(4, "R2"); expect_rr(0, "R3");
      idle("R2");
      idle("R2");
      wait (q_due.size() == 0);
      @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule